// File: doc/BRIEF.md
# DMA Channel Transfer Counter with Reload

This block keeps the remaining transfer count of one DMA channel. Software programs a 24-bit live count through a small register port, and the channel engine pulses a unit strobe each time one transfer unit finishes. The unit can be one byte or a 16-byte burst: each strobe takes exactly one off the count. When the strobe consumes the last unit, the block raises a done pulse in that same cycle.

A second 24-bit register holds a shadow count. Software can rewrite it while a transfer is running. When the reload enable bit is set, the shadow value replaces the live count at the edge that closes the finishing transfer, so the next transfer begins with no software step in between. A programmed count of zero means the largest possible transfer, 2^24 units, and does not end at once.

Top module: `tcnt_top`

## Requirements
- R1: After reset the live count, the shadow count and the reload enable bit all read as zero.
- R2: Registers sit at address 0 (live count), 1 (shadow count) and 2 (control, bit 0 = reload enable). Each reads as 32 bits. Count bits 31:24 and control bits 31:1 always read zero, and writes to them are discarded.
- R3: A strobe accepted with no live-count write in the same cycle lowers the live count by one at the next edge. A live count of 0 becomes 0x00FFFFFF and raises no done, so zero stands for 2^24 units.
- R4: `xfer_done` is high, in the same cycle, exactly when a strobe is accepted while the live count is 1.
- R5: With reload disabled, the live count is 0 after the done edge, and the shadow register has no effect on it.
- R6: With reload enabled, the live count after the done edge equals the shadow value held before that edge.
- R7: Writing the shadow register does not disturb the live count. A shadow write in the done cycle is kept for the following transfer and is not used by the current reload.
- R8: When a live-count write and a strobe fall in the same cycle, the written value is loaded, the strobe is discarded and no done is raised.
- R9: In a cycle with neither a strobe nor a live-count write, the live count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data, combinational |
| unit_strobe | input | 1 | One transfer unit completed |
| xfer_done | output | 1 | Last unit consumed this cycle |

## Verification
A live count that is wrong by even one unit shows on `rd_data` at the very next edge. It also moves the done pulse earlier or later by the same number of strobes. A shadow value latched in the wrong cycle appears as a wrong live count on the first read after the done edge. A strobe that should have been discarded in a collision cycle shows as a count one lower, or as a false done pulse in that same cycle. A zero count mishandled as an empty transfer shows as a done pulse on the first strobe.

// File: rtl/tcnt_pkg.sv
package tcnt_pkg;

    typedef enum logic [1:0] {
        ADDR_LIVE   = 2'd0,
        ADDR_SHADOW = 2'd1,
        ADDR_CTRL   = 2'd2,
        ADDR_NONE   = 2'd3
    } tcnt_addr_e;

endpackage

// File: rtl/tcnt_regs.sv
module tcnt_regs
    import tcnt_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  shadow,
    output logic              reload_en
);

    typedef struct packed {
        logic [CNT_W-1:0] shadow;
        logic             reload_en;
    } regs_t;

    regs_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en && wr_addr == ADDR_SHADOW) begin
            state_d.shadow = wr_data[CNT_W-1:0];
        end
        if (wr_en && wr_addr == ADDR_CTRL) begin
            state_d.reload_en = wr_data[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign shadow    = state_q.shadow;
    assign reload_en = state_q.reload_en;

    AST_SHADOW_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_SHADOW) |=> shadow == $past(wr_data[CNT_W-1:0])); // R7

    AST_SHADOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == ADDR_SHADOW) |=> $stable(shadow)); // R7

endmodule

// File: rtl/tcnt_core.sv
module tcnt_core #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             strobe,
    input  logic             reload_en,
    input  logic [CNT_W-1:0] shadow,
    output logic [CNT_W-1:0] count,
    output logic             done
);

    localparam logic [CNT_W-1:0] LAST_UNIT = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } core_t;

    core_t state_d, state_q;
    logic  accept;
    logic  finish;

    always_comb begin
        state_d = state_q;
        accept  = strobe && !load_en;
        finish  = accept && (state_q.count == LAST_UNIT);
        if (load_en) begin
            state_d.count = load_val;
        end else if (finish && reload_en) begin
            state_d.count = shadow;
        end else if (accept) begin
            state_d.count = state_q.count - LAST_UNIT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign count = state_q.count;
    assign done  = finish;

    AST_ZERO_NEVER_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> !done); // R3

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !load_en && count != LAST_UNIT) |=> count == $past(count) - LAST_UNIT); // R3

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !reload_en) |=> count == '0); // R5

    AST_DONE_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && reload_en) |=> count == $past(shadow)); // R6

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> count == $past(load_val)); // R8

    AST_NO_DONE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> !done); // R8

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && !load_en) |=> $stable(count)); // R9

endmodule

// File: rtl/tcnt_top.sv
module tcnt_top
    import tcnt_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              unit_strobe,
    output logic              xfer_done
);

    logic [CNT_W-1:0] shadow;
    logic             reload_en;
    logic [CNT_W-1:0] live;
    logic             live_wr;

    assign live_wr = wr_en && (wr_addr == ADDR_LIVE);

    tcnt_regs #(
        .CNT_W  (CNT_W),
        .DATA_W (DATA_W)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .shadow    (shadow),
        .reload_en (reload_en)
    );

    tcnt_core #(
        .CNT_W (CNT_W)
    ) i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (live_wr),
        .load_val  (wr_data[CNT_W-1:0]),
        .strobe    (unit_strobe),
        .reload_en (reload_en),
        .shadow    (shadow),
        .count     (live),
        .done      (xfer_done)
    );

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_LIVE:   rd_data = DATA_W'(live);
            ADDR_SHADOW: rd_data = DATA_W'(shadow);
            ADDR_CTRL:   rd_data = DATA_W'(reload_en);
            default:     rd_data = '0;
        endcase
    end

    AST_UPPER_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:CNT_W] == '0); // R2

endmodule

// File: tb/test_tcnt_top.sv
module test_tcnt_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic [1:0]  rd_addr = 2'd0;
    logic [31:0] rd_data;
    logic        unit_strobe = 1'b0;
    logic        xfer_done;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    tcnt_top i_tcnt_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .unit_strobe (unit_strobe),
        .xfer_done   (xfer_done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, capture done before the rising edge.
    task automatic step(input logic w, input logic [1:0] a, input logic [31:0] d,
                        input logic s, output logic done_seen);
        @(negedge clk);
        wr_en = w; wr_addr = a; wr_data = d; unit_strobe = s;
        #1 done_seen = xfer_done;
        @(posedge clk);
        #1;
        wr_en = 1'b0; unit_strobe = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        logic dn;
        step(1'b1, a, d, 1'b0, dn);
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(2'd0, v); check("R1 live", v, 32'h0);
        rd(2'd1, v); check("R1 shadow", v, 32'h0);
        rd(2'd2, v); check("R1 ctrl", v, 32'h0);
    endtask

    task automatic t_regs;
        logic [31:0] v;
        wr(2'd0, 32'hAB12_3456); rd(2'd0, v); check("R2 live mask", v, 32'h0012_3456);
        wr(2'd1, 32'hFF00_0010); rd(2'd1, v); check("R2 shadow mask", v, 32'h0000_0010);
        wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, v); check("R2 ctrl mask", v, 32'h0000_0001);
        wr(2'd2, 32'h0);         rd(2'd2, v); check("R2 ctrl clear", v, 32'h0);
        rd(2'd3, v); check("R2 unused addr", v, 32'h0);
    endtask

    task automatic t_countdown;
        logic [31:0] v;
        logic dn;
        wr(2'd1, 32'h10);
        wr(2'd0, 32'd3);
        step(1'b0, 2'd0, 32'd0, 1'b1, dn); check("R4 no early done", 32'(dn), 32'd0);
        rd(2'd0, v); check("R3 decrement", v, 32'd2);
        step(1'b0, 2'd0, 32'd0, 1'b0, dn);
        rd(2'd0, v); check("R9 hold", v, 32'd2);
        step(1'b0, 2'd0, 32'd0, 1'b1, dn); check("R4 no done at 2", 32'(dn), 32'd0);
        step(1'b0, 2'd0, 32'd0, 1'b1, dn); check("R4 done at 1", 32'(dn), 32'd1);
        rd(2'd0, v); check("R5 zero after done", v, 32'd0);
    endtask

    task automatic t_wrap;
        logic [31:0] v;
        logic dn;
        wr(2'd0, 32'd0);
        step(1'b0, 2'd0, 32'd0, 1'b1, dn); check("R3 zero no done", 32'(dn), 32'd0);
        rd(2'd0, v); check("R3 wrap", v, 32'h00FF_FFFF);
        step(1'b0, 2'd0, 32'd0, 1'b1, dn);
        rd(2'd0, v); check("R3 after wrap", v, 32'h00FF_FFFE);
    endtask

    task automatic t_reload;
        logic [31:0] v;
        logic dn;
        wr(2'd2, 32'd1);
        wr(2'd1, 32'd7);
        wr(2'd0, 32'd2);
        step(1'b0, 2'd0, 32'd0, 1'b1, dn);
        wr(2'd1, 32'd9);
        rd(2'd0, v); check("R7 shadow write keeps live", v, 32'd1);
        step(1'b0, 2'd0, 32'd0, 1'b1, dn); check("R4 done reload", 32'(dn), 32'd1);
        rd(2'd0, v); check("R6 reload value", v, 32'd9);
        wr(2'd1, 32'd4);
        wr(2'd0, 32'd1);
        step(1'b1, 2'd1, 32'd6, 1'b1, dn); check("R4 done with shadow write", 32'(dn), 32'd1);
        rd(2'd0, v); check("R7 old shadow used", v, 32'd4);
        rd(2'd1, v); check("R7 new shadow kept", v, 32'd6);
        wr(2'd0, 32'd1);
        step(1'b0, 2'd0, 32'd0, 1'b1, dn);
        rd(2'd0, v); check("R7 new shadow next transfer", v, 32'd6);
        wr(2'd2, 32'd0);
    endtask

    task automatic t_collide;
        logic [31:0] v;
        logic dn;
        wr(2'd0, 32'd5);
        step(1'b1, 2'd0, 32'h20, 1'b1, dn); check("R8 no done on write", 32'(dn), 32'd0);
        rd(2'd0, v); check("R8 write wins", v, 32'h20);
        wr(2'd0, 32'd1);
        step(1'b1, 2'd0, 32'd1, 1'b1, dn); check("R8 no done at 1", 32'(dn), 32'd0);
        rd(2'd0, v); check("R8 strobe dropped", v, 32'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_regs();
        t_countdown();
        t_wrap();
        t_reload();
        t_collide();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #400000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule